// File: doc/BRIEF.md
# Ready-Time Ordered Response Queue

This block holds pending responses until they may be sent. Each response arrives as a ready time plus a payload tag. The block keeps its entries sorted by ready time and offers the earliest one on a valid/ready output once the internal cycle counter reaches that time. A response that carries no reply is dropped on arrival and takes no slot. Responses with the same ready time leave in the order they arrived.

The block also shows the ready time of the current head (`send_at`), which is the time at which the next send is armed. This value moves to an earlier time whenever a new entry is sorted in ahead of the head. The `empty` flag lets drain logic know that nothing is outstanding. The `full` flag shows that every slot is in use, and while it is high the block ignores new entries.

A three-state controller tracks the head:
- **IDLE**: no entries.
- **HOLD**: entries are present, but the head is not yet due.
- **SEND**: the head is due and offered on the output.

The controller has these transitions:
- **FILL**: IDLE to HOLD or SEND, when the first entry arrives.
- **MATURE**: HOLD to SEND, when the cycle counter reaches the head's ready time.
- **RETIRE**: SEND to HOLD, when a pop leaves a head that is not yet due.
- **DRAIN**: HOLD or SEND to IDLE, when the last entry leaves.

Top module: `trq_top`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `out_valid` is 0. The internal cycle counter starts at 0 in the first cycle after reset is released and advances by one each clock.
- R2: An insert into an empty queue becomes the head. On the next cycle, `empty` is 0 and `send_at` equals the ready time of that insert.
- R3: `out_valid` is 1 exactly when the queue is non-empty and the cycle counter is greater than or equal to the head's ready time. `out_tag` carries the head's tag.
- R4: The head is removed at a clock edge where `out_valid` and `out_ready` are both 1. While `out_ready` is 0, a valid head stays offered with the same tag.
- R5: An insert whose ready time is greater than or equal to the ready time of the last entry is placed after the last entry.
- R6: Any other insert is placed before the first entry whose ready time is strictly greater, so entries with equal ready times leave in arrival order.
- R7: When an insert is placed ahead of the current head, `send_at` changes to the new, earlier ready time on the next cycle. With no insert and no pop, `send_at` holds.
- R8: An insert with `ins_need_resp` = 0 is dropped. It takes no slot and never appears on the output.
- R9: `full` is 1 when all DEPTH slots hold entries. An insert presented while `full` is 1 is ignored, even if a pop happens in the same cycle. `full` and `empty` are never both 1.
- R10: When an insert and a pop happen in the same cycle, the pop is applied first and the new entry is then sorted among the remaining entries.
- R11: An insert whose ready time equals the current cycle is accepted and becomes valid on the next cycle.
- R12: The caller never presents an insert whose ready time is earlier than the current cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request this cycle |
| ins_need_resp | input | 1 | Insert carries a response; 0 means drop it |
| ins_time | input | TIME_W | Ready time of the inserted entry |
| ins_tag | input | TAG_W | Payload tag of the inserted entry |
| out_valid | output | 1 | Head entry is due and offered |
| out_ready | input | 1 | Port accepts the offered head |
| out_tag | output | TAG_W | Tag of the head entry |
| send_at | output | TIME_W | Ready time of the head (the armed send time) |
| empty | output | 1 | No entries held |
| full | output | 1 | All slots occupied |

## Verification
The checker watches four things on every cycle:
- the output is offered exactly when the head is due against the cycle counter;
- a stalled head keeps its tag;
- a dropped insert leaves an empty queue empty, and a full queue without a pop stays full;
- the armed send time only moves on an insert or a pop.

The sorted placement can only be seen from the bench's scenarios, because it shows in the order in which tags leave. Those scenarios cover:
- ties leaving first-in-first-out;
- an earlier insert overtaking the head;
- an insert colliding with a pop in the same cycle;
- an ignored insert into a full queue that never emerges.

// File: rtl/trq_pkg.sv
package trq_pkg;

    // Controller states for the head of the queue
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // nothing held
        ST_HOLD = 2'd1,   // entries held, head not yet due
        ST_SEND = 2'd2    // head due and offered
    } trq_state_e;

endpackage

// File: rtl/trq_timebase.sv
module trq_timebase #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] now_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_q <= '0;
        end else begin
            now_q <= now_q + TIME_W'(1);
        end
    end

endmodule

// File: rtl/trq_store.sv
// Sorted entry store: pop shifts everything down by one, then the new entry
// is slotted after every remaining entry whose time is not later than its own.
module trq_store #(
    parameter int DEPTH  = 8,
    parameter int TIME_W = 16,
    parameter int TAG_W  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              ins_en,
    input  logic [TIME_W-1:0] ins_time,
    input  logic [TAG_W-1:0]  ins_tag,
    output logic [TIME_W-1:0] head_time,
    output logic [TAG_W-1:0]  head_tag,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  nxt_cnt,
    output logic [TIME_W-1:0] nxt_head_time
);

    logic [DEPTH-1:0][TIME_W-1:0] t_q, t_p, t_n;
    logic [DEPTH-1:0][TAG_W-1:0]  g_q, g_p, g_n;
    logic [DEPTH-1:0]             keep_lo;
    logic [CNT_W-1:0]             cnt_q, cnt_p;

    assign cnt_p   = cnt_q - CNT_W'(pop);
    assign nxt_cnt = cnt_p + CNT_W'(ins_en);

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_slot
            // view after the pop has been applied
            if (i == DEPTH - 1) begin : g_last
                assign t_p[i] = pop ? '0 : t_q[i];
                assign g_p[i] = pop ? '0 : g_q[i];
            end else begin : g_mid
                assign t_p[i] = pop ? t_q[i+1] : t_q[i];
                assign g_p[i] = pop ? g_q[i+1] : g_q[i];
            end

            // remaining entry i stays ahead of the new one
            assign keep_lo[i] = (CNT_W'(i) < cnt_p) && (t_p[i] <= ins_time);

            // sorted placement
            if (i == 0) begin : g_first
                assign t_n[i] = (!ins_en || keep_lo[i]) ? t_p[i] : ins_time;
                assign g_n[i] = (!ins_en || keep_lo[i]) ? g_p[i] : ins_tag;
            end else begin : g_rest
                assign t_n[i] = (!ins_en || keep_lo[i]) ? t_p[i] :
                                (keep_lo[i-1] ? ins_time : t_p[i-1]);
                assign g_n[i] = (!ins_en || keep_lo[i]) ? g_p[i] :
                                (keep_lo[i-1] ? ins_tag : g_p[i-1]);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q   <= '0;
            g_q   <= '0;
            cnt_q <= '0;
        end else begin
            t_q   <= t_n;
            g_q   <= g_n;
            cnt_q <= nxt_cnt;
        end
    end

    assign head_time     = t_q[0];
    assign head_tag      = g_q[0];
    assign cnt           = cnt_q;
    assign nxt_head_time = t_n[0];

endmodule

// File: rtl/trq_ctrl.sv
module trq_ctrl
    import trq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TIME_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now_q,
    input  logic [CNT_W-1:0]  nxt_cnt,
    input  logic [TIME_W-1:0] nxt_head_time,
    output logic              out_valid,
    output logic              empty
);

    trq_state_e        st_q, st_d;
    logic [TIME_W-1:0] now_nx;
    logic              due_nx;
    logic              have_nx;

    assign now_nx  = now_q + TIME_W'(1);
    assign have_nx = (nxt_cnt != '0);
    assign due_nx  = (nxt_head_time <= now_nx);

    // next-state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (have_nx) st_d = due_nx ? ST_SEND : ST_HOLD;   // FILL
            end
            ST_HOLD: begin
                if (!have_nx)    st_d = ST_IDLE;                  // DRAIN
                else if (due_nx) st_d = ST_SEND;                  // MATURE
            end
            ST_SEND: begin
                if (!have_nx)     st_d = ST_IDLE;                 // DRAIN
                else if (!due_nx) st_d = ST_HOLD;                 // RETIRE
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        out_valid = (st_q == ST_SEND);
        empty     = (st_q == ST_IDLE);
    end

endmodule

// File: rtl/trq_top.sv
module trq_top #(
    parameter int DEPTH  = 8,
    parameter int TIME_W = 16,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic              ins_need_resp,
    input  logic [TIME_W-1:0] ins_time,
    input  logic [TAG_W-1:0]  ins_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TAG_W-1:0]  out_tag,
    output logic [TIME_W-1:0] send_at,
    output logic              empty,
    output logic              full
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TIME_W-1:0] cur_time;
    logic [CNT_W-1:0]  cnt, nxt_cnt;
    logic [TIME_W-1:0] nxt_head_time;
    logic              pop, ins_en;

    assign full   = (cnt == CNT_W'(DEPTH));
    assign pop    = out_valid && out_ready;
    assign ins_en = ins_valid && ins_need_resp && !full;

    trq_timebase #(.TIME_W(TIME_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .now_q (cur_time)
    );

    trq_store #(.DEPTH(DEPTH), .TIME_W(TIME_W), .TAG_W(TAG_W)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .pop           (pop),
        .ins_en        (ins_en),
        .ins_time      (ins_time),
        .ins_tag       (ins_tag),
        .head_time     (send_at),
        .head_tag      (out_tag),
        .cnt           (cnt),
        .nxt_cnt       (nxt_cnt),
        .nxt_head_time (nxt_head_time)
    );

    trq_ctrl #(.DEPTH(DEPTH), .TIME_W(TIME_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .now_q         (cur_time),
        .nxt_cnt       (nxt_cnt),
        .nxt_head_time (nxt_head_time),
        .out_valid     (out_valid),
        .empty         (empty)
    );

endmodule

// File: rtl/trq_chk.sv
module trq_chk #(
    parameter int TIME_W = 16,
    parameter int TAG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ins_valid,
    input logic              ins_need_resp,
    input logic [TIME_W-1:0] ins_time,
    input logic              out_valid,
    input logic              out_ready,
    input logic [TAG_W-1:0]  out_tag,
    input logic [TIME_W-1:0] send_at,
    input logic              empty,
    input logic              full,
    input logic [TIME_W-1:0] cur_time
);

    p_valid_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !empty);

    p_valid_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (send_at <= cur_time));

    p_due_offered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && (send_at <= cur_time)) |-> out_valid);

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag)));

    p_send_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !(ins_valid && ins_need_resp) && !(out_valid && out_ready))
            |=> $stable(send_at));

    p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && ins_valid && !ins_need_resp) |=> empty);

    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(out_valid && out_ready)) |=> full);

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_ins_not_past_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_need_resp) |-> (ins_time >= cur_time));

endmodule

bind trq_top trq_chk #(.TIME_W(TIME_W), .TAG_W(TAG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ins_valid     (ins_valid),
    .ins_need_resp (ins_need_resp),
    .ins_time      (ins_time),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_tag       (out_tag),
    .send_at       (send_at),
    .empty         (empty),
    .full          (full),
    .cur_time      (cur_time)
);

// File: tb/tb_trq_top.sv
`timescale 1ns/1ps
module tb_trq_top;

    localparam int DEPTH  = 8;
    localparam int TIME_W = 16;
    localparam int TAG_W  = 8;
    localparam int NROWS  = 16;

    // row: {ins_valid, need_resp, dt[7:0], tag[7:0], out_ready}
    localparam logic [18:0] STIM [NROWS] = '{
        {1'b1, 1'b1, 8'd5, 8'h71, 1'b0},
        {1'b1, 1'b1, 8'd2, 8'h72, 1'b0},
        {1'b1, 1'b1, 8'd2, 8'h73, 1'b0},
        {1'b1, 1'b0, 8'd0, 8'h74, 1'b0},
        {1'b1, 1'b1, 8'd9, 8'h75, 1'b1},
        {1'b0, 1'b0, 8'd0, 8'h00, 1'b1},
        {1'b1, 1'b1, 8'd0, 8'h76, 1'b1},
        {1'b1, 1'b1, 8'd3, 8'h77, 1'b0},
        {1'b0, 1'b0, 8'd0, 8'h00, 1'b0},
        {1'b1, 1'b1, 8'd1, 8'h78, 1'b1},
        {1'b0, 1'b0, 8'd0, 8'h00, 1'b1},
        {1'b1, 1'b1, 8'd4, 8'h79, 1'b0},
        {1'b0, 1'b0, 8'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 8'd0, 8'h00, 1'b1},
        {1'b1, 1'b1, 8'd2, 8'h7A, 1'b1},
        {1'b0, 1'b0, 8'd0, 8'h00, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ins_valid = 1'b0;
    logic              ins_need_resp = 1'b0;
    logic [TIME_W-1:0] ins_time = '0;
    logic [TAG_W-1:0]  ins_tag = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [TAG_W-1:0]  out_tag;
    logic [TIME_W-1:0] send_at;
    logic              empty;
    logic              full;

    always #4 clk = ~clk;   // 125 MHz

    trq_top #(.DEPTH(DEPTH), .TIME_W(TIME_W), .TAG_W(TAG_W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ins_valid     (ins_valid),
        .ins_need_resp (ins_need_resp),
        .ins_time      (ins_time),
        .ins_tag       (ins_tag),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_tag       (out_tag),
        .send_at       (send_at),
        .empty         (empty),
        .full          (full)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int tb_now   = 0;
    bit summary_done = 0;

    // reference queue built from the requirements
    int m_t [DEPTH];
    int m_g [DEPTH];
    int m_cnt = 0;

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at cycle %0d",
                     what, act, act, exp, exp, tb_now);
        end
    endtask

    task automatic model_update(input bit v, input bit need, input int t,
                                input int tag, input bit rdy, input int n);
        bit pop;
        bit acc;
        int p;
        pop = (m_cnt > 0) && (m_t[0] <= n) && rdy;
        acc = v && need && (m_cnt < DEPTH);   // full judged before the pop (R9)
        if (pop) begin
            for (int k = 0; k < DEPTH - 1; k++) begin
                m_t[k] = m_t[k+1];
                m_g[k] = m_g[k+1];
            end
            m_cnt--;
        end
        if (acc) begin
            p = 0;
            while (p < m_cnt && m_t[p] <= t) p++;
            for (int k = DEPTH - 1; k > 0; k--) begin
                if (k > p) begin
                    m_t[k] = m_t[k-1];
                    m_g[k] = m_g[k-1];
                end
            end
            m_t[p] = t;
            m_g[p] = tag;
            m_cnt++;
        end
    endtask

    task automatic compare_all();
        bit mv;
        mv = (m_cnt > 0) && (m_t[0] <= tb_now);
        check("R3 out_valid", int'(out_valid), int'(mv));
        check("R1 empty flag", int'(empty), int'(m_cnt == 0));
        check("R9 full flag", int'(full), int'(m_cnt == DEPTH));
        if (mv)        check("R6 head tag order", int'(out_tag), m_g[0]);
        if (m_cnt > 0) check("R7 send time", int'(send_at), m_t[0]);
    endtask

    // one clock: compare, drive, advance, update the model
    task automatic step(input bit v, input bit need, input int dt,
                        input int tag, input bit rdy);
        compare_all();
        ins_valid     = v;
        ins_need_resp = need;
        ins_time      = TIME_W'(tb_now + dt);
        ins_tag       = TAG_W'(tag);
        out_ready     = rdy;
        @(posedge clk);
        model_update(v, need, tb_now + dt, tag, rdy, tb_now);
        tb_now++;
        @(negedge clk);
        ins_valid = 1'b0;
        out_ready = 1'b0;
    endtask

    task automatic ins_at(input int abs_t, input int tag, input bit rdy);
        step(1'b1, 1'b1, abs_t - tb_now, tag, rdy);
    endtask

    task automatic idle(input int n, input bit rdy);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 0, 0, rdy);
    endtask

    // wait for the next offered head, check its tag, then accept it
    task automatic expect_out(input string what, input int exp_tag);
        int guard;
        guard = 0;
        while (!out_valid && guard < 64) begin
            step(1'b0, 1'b0, 0, 0, 1'b0);
            guard++;
        end
        check(what, out_valid ? int'(out_tag) : -1, exp_tag);
        step(1'b0, 1'b0, 0, 0, 1'b1);
    endtask

    task automatic flush();
        int guard;
        guard = 0;
        while (m_cnt > 0 && guard < 200) begin
            step(1'b0, 1'b0, 0, 0, 1'b1);
            guard++;
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        int t0;
        repeat (3) @(posedge clk);
        @(negedge clk);

        // R1: reset state, observed while reset is still applied
        check("R1 empty after reset", int'(empty), 1);
        check("R1 full after reset", int'(full), 0);
        check("R1 out_valid after reset", int'(out_valid), 0);
        rst_n  = 1'b1;
        tb_now = 0;
        idle(2, 1'b1);

        // R8: a no-response insert is dropped
        step(1'b1, 1'b0, 0, 8'h11, 1'b1);
        check("R8 dropped insert leaves queue empty", int'(empty), 1);
        idle(3, 1'b1);
        check("R8 dropped insert never offered", int'(out_valid), 0);

        // R2, R11: insert at the current cycle into an empty queue
        t0 = tb_now;
        step(1'b1, 1'b1, 0, 8'h21, 1'b0);
        check("R2 head present", int'(empty), 0);
        check("R2 send time of first insert", int'(send_at), t0);
        check("R11 same-cycle ready time valid next cycle", int'(out_valid), 1);
        step(1'b0, 1'b0, 0, 0, 1'b0);
        check("R4 stalled head kept", int'(out_tag), 8'h21);
        step(1'b0, 1'b0, 0, 0, 1'b1);
        check("R4 pop empties queue", int'(empty), 1);

        // R7: earlier insert overtakes the head and rearms the send time
        t0 = tb_now;
        ins_at(t0 + 20, 8'h31, 1'b0);
        check("R7 armed at first time", int'(send_at), t0 + 20);
        ins_at(t0 + 6, 8'h32, 1'b0);
        check("R7 rearmed to earlier time", int'(send_at), t0 + 6);
        expect_out("R6 earlier entry first", 8'h32);
        expect_out("R5 later entry second", 8'h31);

        // R5, R6: ties keep arrival order, a strictly earlier entry cuts in
        t0 = tb_now + 15;
        ins_at(t0, 8'h41, 1'b0);
        ins_at(t0, 8'h42, 1'b0);
        ins_at(t0 + 7, 8'h44, 1'b0);
        ins_at(t0, 8'h43, 1'b0);
        ins_at(t0 - 3, 8'h45, 1'b0);
        expect_out("R6 earliest first", 8'h45);
        expect_out("R6 tie order first", 8'h41);
        expect_out("R6 tie order second", 8'h42);
        expect_out("R6 tie order third", 8'h43);
        expect_out("R5 appended tail", 8'h44);
        check("R6 queue drained", int'(empty), 1);

        // R9: fill, ignore inserts while full, including with a pop
        t0 = tb_now + 12;
        for (int k = 0; k < DEPTH; k++) ins_at(t0 + k, 8'h50 + k, 1'b0);
        check("R9 full after DEPTH inserts", int'(full), 1);
        ins_at(t0 + 1, 8'h5F, 1'b0);
        check("R9 still full after ignored insert", int'(full), 1);
        while (!out_valid && tb_now < t0 + 40) idle(1, 1'b0);
        ins_at(tb_now, 8'h5E, 1'b1);   // pop and insert together while full
        check("R9 insert ignored while full, pop applied", int'(full), 0);
        for (int k = 1; k < DEPTH; k++) expect_out("R9 stored entries only", 8'h50 + k);
        check("R9 ignored inserts never appear", int'(empty), 1);

        // R10: pop and insert in the same cycle
        t0 = tb_now;
        ins_at(t0, 8'h61, 1'b0);
        ins_at(t0 + 10, 8'h62, 1'b0);
        check("R10 head due", int'(out_valid), 1);
        ins_at(tb_now, 8'h63, 1'b1);
        check("R10 new entry sorted after pop", int'(out_tag), 8'h63);
        check("R10 new head offered", int'(out_valid), 1);
        expect_out("R10 new entry first", 8'h63);
        expect_out("R10 remaining entry last", 8'h62);

        // table-driven mixed traffic against the reference queue
        for (int i = 0; i < NROWS; i++) begin
            step(STIM[i][18], STIM[i][17], int'(STIM[i][16:9]),
                 int'(STIM[i][8:1]), STIM[i][0]);
        end
        flush();
        check("R1 empty after flush", int'(empty), 1);
        idle(2, 1'b1);

        finish_run();
    end

endmodule